// File: doc/BRIEF.md
# Drive-Enable Startup Sequencer

This block decides when a three-phase motor predriver may switch its outputs on. It watches a drive request and feeds a saturating accumulator that stands in for a charged capacitor. The accumulator climbs by a large step in every clock cycle that the request is active. It falls by a small step in every cycle that the request is idle. The drive is enabled only after enough on-time has built up to push the accumulator above an upper threshold. It is dropped again only when the accumulator has leaked below a lower threshold. A chopped request therefore reaches the enable only after several pulses, and the outputs stay on through short gaps in the request.

The request comes from one of two sources, picked by a select input. One is an active-low pulse input, where a low level asks for drive. The other is an active-high duty comparator result. A stop input empties the accumulator and forces the reset state. The reset flag is the complement of the enable flag, and a neighbouring stall-protection latch uses it as its clear signal.

Top module: `drive_gate_seq`

## Requirements
- R1: A synchronous active-low reset clears the accumulator to zero and drives `drive_en` low. Reaching enable afterwards needs the full number of request cycles counted from zero (18 cycles with the default parameters).
- R2: With `src_sel` = 0 the request is active while `pwm_in_n` is low, and `duty_cmp` is ignored. With `src_sel` = 1 the request is active while `duty_cmp` is high, and `pwm_in_n` is ignored.
- R3: In each cycle that the request is active and `halt` is low, the accumulator rises by `RISE_STEP`. It saturates at the full-scale value 2^`ACC_W`-1 and never wraps.
- R4: In each cycle that the request is idle and `halt` is low, the accumulator falls by `FALL_STEP`. It stops at zero and never wraps.
- R5: `drive_en` rises one clock after the registered accumulator is strictly greater than `HI_TH`. A value equal to `HI_TH` does not set it.
- R6: `drive_en` falls one clock after the registered accumulator is strictly less than `LO_TH`. A value between `LO_TH` and `HI_TH`, inclusive, leaves `drive_en` unchanged.
- R7: When `halt` is high at a clock edge, the accumulator is zeroed and `drive_en` is low after that edge, whatever the request.
- R8: `seq_rst` is always the complement of `drive_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Stop command, active high; forces the reset state |
| src_sel | input | 1 | Request source: 0 = pulse input, 1 = duty comparator |
| pwm_in_n | input | 1 | Pulse drive request, active low |
| duty_cmp | input | 1 | Duty comparator result, active high |
| drive_en | output | 1 | Drive enable flag |
| seq_rst | output | 1 | Reset-state flag, also the stall latch clear |

## Verification
The sequencer is driven with a steady request from zero, with short bursts separated by long idle stretches, with a request held until full scale, and with idle stretches long enough to hit the floor. A steady request from zero fixes the exact cycle of the registered upper crossing, and it shows that a value equal to the threshold does not enable. A decay stepped one cycle at a time through the lower threshold shows the same strict rule on the way down. The drain from full scale takes an exact number of cycles, and so does the climb after a long idle stretch; both counts change if either bound wraps. Each source is also run while the other source is active, so any leak through the select shows up as an early enable. The halt and mid-run reset checks show that both restart the climb from zero.

// File: rtl/dgs_pkg.sv
// Package: shared types for the drive-enable sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dgs_pkg;

    // Which input supplies the drive request.
    typedef enum logic {
        SRC_PULSE_PIN = 1'b0,
        SRC_DUTY_CMP  = 1'b1
    } src_e;

    // Position of the accumulator relative to the two thresholds.
    typedef enum logic [1:0] {
        ZONE_BELOW = 2'd0,
        ZONE_BAND  = 2'd1,
        ZONE_ABOVE = 2'd2
    } zone_e;

endpackage

// File: rtl/dgs_req_sel.sv
// Module: dgs_req_sel
// Turns the chosen source into one active-high request bit.
// Assumes both inputs are already synchronous to clk.
module dgs_req_sel
    import dgs_pkg::*;
(
    input  logic src_sel,
    input  logic pwm_in_n,
    input  logic duty_cmp,
    output logic req
);

    src_e src;

    // Map the select bit onto the source enum.
    always_comb begin
        src = src_e'(src_sel);
    end

    // Pick the request: a low pulse pin or a high comparator result.
    always_comb begin
        unique case (src)
            SRC_PULSE_PIN: req = ~pwm_in_n;
            SRC_DUTY_CMP:  req = duty_cmp;
            default:       req = 1'b0;
        endcase
    end

endmodule

// File: rtl/dgs_leaky_acc.sv
// Module: dgs_leaky_acc
// Leaky integrator. It rises by RISE_STEP while the request is active,
// falls by FALL_STEP while it is idle, and is clamped to [0, 2^ACC_W-1].
// Assumes both steps fit into ACC_W bits. halt zeroes it.
module dgs_leaky_acc #(
    parameter int ACC_W     = 10,
    parameter int RISE_STEP = 16,
    parameter int FALL_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             req,
    output logic [ACC_W-1:0] acc
);

    localparam logic [ACC_W-1:0] RISE_V = RISE_STEP[ACC_W-1:0];
    localparam logic [ACC_W-1:0] FALL_V = FALL_STEP[ACC_W-1:0];
    localparam logic [ACC_W-1:0] FULL_V = {ACC_W{1'b1}};

    logic [ACC_W:0]   up_sum;
    logic [ACC_W-1:0] up_val;
    logic [ACC_W-1:0] dn_val;
    logic [ACC_W-1:0] acc_q;

    // Saturating add: a carry out clamps to full scale.
    always_comb begin
        up_sum = {1'b0, acc_q} + {1'b0, RISE_V};
        up_val = up_sum[ACC_W] ? FULL_V : up_sum[ACC_W-1:0];
    end

    // Saturating subtract: a borrow clamps to zero.
    always_comb begin
        dn_val = (acc_q < FALL_V) ? '0 : (acc_q - FALL_V);
    end

    // Accumulator register, with reset and halt taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (halt) begin
            acc_q <= '0;
        end else if (req) begin
            acc_q <= up_val;
        end else begin
            acc_q <= dn_val;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/dgs_zone_cmp.sv
// Module: dgs_zone_cmp
// Sorts the accumulator into below-low, band or above-high.
// Both comparisons are strict, so equal values fall in the band.
// Assumes LO_TH < HI_TH and both are below 2^ACC_W.
module dgs_zone_cmp
    import dgs_pkg::*;
#(
    parameter int ACC_W = 10,
    parameter int HI_TH = 256,
    parameter int LO_TH = 113
) (
    input  logic [ACC_W-1:0] acc,
    output zone_e            zone
);

    localparam logic [ACC_W-1:0] HI_V = HI_TH[ACC_W-1:0];
    localparam logic [ACC_W-1:0] LO_V = LO_TH[ACC_W-1:0];

    // Strict threshold classification.
    always_comb begin
        if (acc > HI_V) begin
            zone = ZONE_ABOVE;
        end else if (acc < LO_V) begin
            zone = ZONE_BELOW;
        end else begin
            zone = ZONE_BAND;
        end
    end

endmodule

// File: rtl/dgs_hyst_flag.sv
// Module: dgs_hyst_flag
// Registered enable with hysteresis: it sets above the band, clears below
// it and holds inside it. Reset and halt clear it.
module dgs_hyst_flag
    import dgs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  halt,
    input  zone_e zone,
    output logic  en
);

    logic en_q;

    // The flag changes only on a zone crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (halt) begin
            en_q <= 1'b0;
        end else begin
            unique case (zone)
                ZONE_ABOVE: en_q <= 1'b1;
                ZONE_BELOW: en_q <= 1'b0;
                default:    en_q <= en_q;
            endcase
        end
    end

    assign en = en_q;

endmodule

// File: rtl/drive_gate_seq.sv
// Module: drive_gate_seq (top)
// Drive-enable sequencer. Request on-time charges a leaky accumulator.
// Hysteresis thresholds on that accumulator produce drive_en, and seq_rst
// is its complement, used as the clear for the stall latch.
// Assumes synchronous inputs and LO_TH < HI_TH < 2^ACC_W.
module drive_gate_seq
    import dgs_pkg::*;
#(
    parameter int ACC_W     = 10,
    parameter int RISE_STEP = 16,
    parameter int FALL_STEP = 1,
    parameter int HI_TH     = 256,
    parameter int LO_TH     = 113
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic src_sel,
    input  logic pwm_in_n,
    input  logic duty_cmp,
    output logic drive_en,
    output logic seq_rst
);

    logic             req;
    logic [ACC_W-1:0] acc_q;
    zone_e            zone;
    logic             en;

    dgs_req_sel u_sel (
        .src_sel  (src_sel),
        .pwm_in_n (pwm_in_n),
        .duty_cmp (duty_cmp),
        .req      (req)
    );

    dgs_leaky_acc #(
        .ACC_W     (ACC_W),
        .RISE_STEP (RISE_STEP),
        .FALL_STEP (FALL_STEP)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .req   (req),
        .acc   (acc_q)
    );

    dgs_zone_cmp #(
        .ACC_W (ACC_W),
        .HI_TH (HI_TH),
        .LO_TH (LO_TH)
    ) u_cmp (
        .acc  (acc_q),
        .zone (zone)
    );

    dgs_hyst_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .zone  (zone),
        .en    (en)
    );

    // Output flags: the enable and its complement.
    assign drive_en = en;
    assign seq_rst  = ~en;

endmodule

// File: rtl/drive_gate_seq_chk.sv
// Module: drive_gate_seq_chk
// Assertion checker bound onto drive_gate_seq. It watches the request,
// the accumulator and the flags.
module drive_gate_seq_chk #(
    parameter int ACC_W = 10,
    parameter int HI_TH = 256,
    parameter int LO_TH = 113
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             req,
    input logic [ACC_W-1:0] acc,
    input logic             drive_en,
    input logic             seq_rst
);

    localparam logic [ACC_W-1:0] HI_V = HI_TH[ACC_W-1:0];
    localparam logic [ACC_W-1:0] LO_V = LO_TH[ACC_W-1:0];

    // R1: a reset cycle leaves the accumulator empty and the drive off
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && !drive_en));

    // R3: while requesting, the accumulator never goes down (no wrap)
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && req) |=> acc >= $past(acc));

    // R4: while idle, the accumulator never goes up (no wrap)
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !req) |=> acc <= $past(acc));

    // R5: strictly above the upper threshold sets the enable
    p_enable_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && acc > HI_V) |=> drive_en);

    // R6: strictly below the lower threshold clears the enable
    p_enable_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && acc < LO_V) |=> !drive_en);

    // R6: inside the band the enable holds its value
    p_band_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && acc >= LO_V && acc <= HI_V) |=> $stable(drive_en));

    // R7: halt empties the accumulator and drops the drive
    p_halt_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (acc == '0 && !drive_en));

    // R8: the reset flag is always the complement of the enable
    p_flag_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en != seq_rst);

endmodule

bind drive_gate_seq drive_gate_seq_chk #(
    .ACC_W (ACC_W),
    .HI_TH (HI_TH),
    .LO_TH (LO_TH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .req      (req),
    .acc      (acc_q),
    .drive_en (drive_en),
    .seq_rst  (seq_rst)
);

// File: tb/tb_drive_gate_seq.sv
`timescale 1ns/1ps
// Bench for drive_gate_seq with default parameters:
// ACC_W=10, RISE_STEP=16, FALL_STEP=1, HI_TH=256, LO_TH=113.
module tb_drive_gate_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0;
    logic src_sel = 1'b0;
    logic pwm_in_n = 1'b1;
    logic duty_cmp = 1'b0;
    logic drive_en;
    logic seq_rst;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    drive_gate_seq dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .src_sel  (src_sel),
        .pwm_in_n (pwm_in_n),
        .duty_cmp (duty_cmp),
        .drive_en (drive_en),
        .seq_rst  (seq_rst)
    );

    typedef struct packed {
        logic        h;
        logic        sel;
        logic        pn;
        logic        dc;
        logic [11:0] cyc;
        logic        exp_en;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd10,  1'b0, 8'd1}, // R1: 160 from empty
        '{1'b0, 1'b0, 1'b1, 1'b1, 12'd20,  1'b0, 8'd2}, // R2: cmp ignored, 140
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd8,   1'b0, 8'd5}, // R5: 268, flag saw 252
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd1,   1'b1, 8'd5}, // R5: crossing seen
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'd150, 1'b1, 8'd4}, // R4: 134, holds
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'd21,  1'b1, 8'd6}, // R6: 113
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'd1,   1'b1, 8'd6}, // R6: equal to low holds
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'd1,   1'b0, 8'd6}, // R6: 112 clears
        '{1'b0, 1'b1, 1'b1, 1'b1, 12'd70,  1'b1, 8'd3}, // R3: to full scale
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'd911, 1'b1, 8'd3}, // R3: saturated drain
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'd1,   1'b0, 8'd3}, // R3: exact drain time
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'd20,  1'b0, 8'd2}, // R2: pin ignored
        '{1'b0, 1'b1, 1'b1, 1'b0, 12'd200, 1'b0, 8'd4}, // R4: floor at zero
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd17,  1'b0, 8'd4}, // R4: climb from zero
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd1,   1'b1, 8'd5}, // R5: equal high skipped
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'd3,   1'b0, 8'd7}, // R7: halt drops drive
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd17,  1'b0, 8'd7}, // R7: restart from zero
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'd1,   1'b1, 8'd7}  // R7: enabled again
    };

    task automatic check_en(input logic exp, input int rq, input string what);
        n_chk++;
        if (drive_en !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: drive_en=%b expected %b", rq, what, drive_en, exp);
        end
        n_chk++;
        if (seq_rst !== ~exp) begin // R8
            n_err++;
            $display("FAIL R8 %s: seq_rst=%b expected %b", what, seq_rst, ~exp);
        end
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        run_cycles(3);
        rst_n = 1'b1;
        check_en(1'b0, 1, "R1 state after reset");

        for (int i = 0; i < NV; i++) begin
            halt     = VEC[i].h;
            src_sel  = VEC[i].sel;
            pwm_in_n = VEC[i].pn;
            duty_cmp = VEC[i].dc;
            run_cycles(int'(VEC[i].cyc));
            check_en(VEC[i].exp_en, int'(VEC[i].rq), $sformatf("vector %0d", i));
        end

        // R1: a mid-run reset drops the drive and empties the accumulator
        rst_n = 1'b0;
        run_cycles(1);
        rst_n = 1'b1;
        check_en(1'b0, 1, "R1 mid-run reset");
        run_cycles(17);
        check_en(1'b0, 1, "R1 climb restarts at zero");
        run_cycles(1);
        check_en(1'b1, 1, "R1 enable after 18 cycles");

        // R7: a single halt cycle in the band still clears the enable
        pwm_in_n = 1'b1;
        run_cycles(50);
        check_en(1'b1, 6, "R6 band hold before halt");
        halt = 1'b1;
        run_cycles(1);
        halt = 1'b0;
        check_en(1'b0, 7, "R7 single halt cycle");
        pwm_in_n = 1'b0;
        run_cycles(17);
        check_en(1'b0, 7, "R7 accumulator emptied by halt");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule